// File: doc/BRIEF.md
# Programmable Product-Term AND-OR Array

This block is the logic core of a sum-of-products device. It has twelve dedicated logic inputs and ten feedback inputs. Those 22 signals make up the array vector, and every product term sees each of them in both true and inverted form. For each of the ten outputs the array builds eight product terms and ORs them into one sum. A ninth product term per output is kept apart from the sum and is presented as that output's enable term. The output cells, their registers and the pin drivers sit outside this block. The register outputs come back into it through the feedback inputs, so next-state logic can be built.

Which literals feed which term is held in an on-chip connection map, one word per product term. The map is written through a valid/ready configuration port. A word is taken on every clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low only while reset is held, and during the first edge after reset is released. A writer facing a low `cfg_ready` keeps its word and its valid signal steady until ready returns. Once a word is stored, the path from inputs to outputs is purely combinational. Reset leaves the map in its blank state: every literal is connected, so every term is false.

Top module: `prog_pterm_array`

## Requirements
- R1: The array vector has 22 bits. Bits 0 to 11 are `ded_in[0..11]` and bits 12 to 21 are `fb_in[0..9]`. Every product term can use any bit of it.
- R2: A connection word has 44 bits. For vector bit i, word bit 2i connects the true literal and word bit 2i+1 connects the inverted literal. A term is 1 exactly when every connected literal is 1.
- R3: A term whose word is all zeros (no literal connected) evaluates to 1 for every input.
- R4: A term that has both literals of any one vector bit connected evaluates to 0 for every input.
- R5: Product term k has address k. Output o owns addresses 9o to 9o+8. `sum_out[o]` is the OR of the terms at 9o to 9o+7.
- R6: `oe_term[o]` equals the term at address 9o+8, and that term has no effect on `sum_out[o]`.
- R7: While reset is held, every map word is all ones. Until the first write, every bit of `sum_out` and `oe_term` is 0.
- R8: A write is taken on an edge where `cfg_valid` and `cfg_ready` are both high. It replaces the whole word at `cfg_addr`, and the outputs reflect it from that edge on. With `cfg_valid` low nothing changes. Valid held high over consecutive cycles writes one word per cycle.
- R9: `cfg_ready` is 0 during reset and at the first edge after release, and 1 from then on. A taken write to an address of 90 or above changes no output.
- R10: With the map unchanged, the outputs follow `ded_in` and `fb_in` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the connection map |
| rst_n | input | 1 | Asynchronous active-low reset; blanks the map |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Map can take a word |
| cfg_addr | input | 7 | Product-term address of the word |
| cfg_data | input | 44 | Connection word, two bits per vector bit |
| ded_in | input | 12 | Dedicated logic inputs |
| fb_in | input | 10 | Feedback inputs from the output registers |
| sum_out | output | 10 | Sum of eight product terms per output |
| oe_term | output | 10 | Enable product term per output |

## Verification
Hand-built terms are each driven with the input values that make them true and false:
- one term joins a dedicated true literal with a feedback inverted literal, which shows the bit order and the polarity coding;
- an open term and a term with both literals of one input show the two degenerate cases;
- a term placed in the enable slot shows that the enable is kept out of the sum.

Writes with valid low, writes to addresses above the last term, back-to-back writes and overwrites show which words the port changes. A long phase of sparse random maps with random inputs and feedback is checked against a behavioural model on every cycle. That phase tests the OR of all eight slots, including several terms true at once.

// File: rtl/pterm_pkg.sv
`timescale 1ns/1ps
package pterm_pkg;

  // Two connection bits per vector bit: bit 0 = true literal, bit 1 = inverted literal.
  typedef enum logic [1:0] {
    LIT_OPEN = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_INV  = 2'b10,
    LIT_BOTH = 2'b11
  } lit_e;

  localparam int unsigned LIT_BITS = 2;

  // Address of slot s of output o when each output owns 'slots' terms.
  function automatic int unsigned term_addr(int unsigned o, int unsigned s, int unsigned slots);
    return o * slots + s;
  endfunction

endpackage

// File: rtl/pterm_eval.sv
`timescale 1ns/1ps
module pterm_eval
  import pterm_pkg::*;
#(
  parameter int unsigned VEC_W = 22,
  localparam int unsigned WORD_W = LIT_BITS * VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic [VEC_W-1:0]  vec,
  output logic              hit
);

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < VEC_W; i++) begin
      case (lit_e'(word[LIT_BITS*i +: LIT_BITS]))
        LIT_TRUE: if (!vec[i]) hit = 1'b0;
        LIT_INV:  if (vec[i])  hit = 1'b0;
        LIT_BOTH: hit = 1'b0;
        default:  ;
      endcase
    end
  end

  // Checks: a word with no literal is a constant 1; a word with a literal pair is a constant 0.
  logic pair_seen;
  always_comb begin
    pair_seen = 1'b0;
    for (int j = 0; j < VEC_W; j++)
      pair_seen = pair_seen | (word[2*j] & word[2*j+1]);
  end

  assert_open_term_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word == '0) |-> hit);

  assert_pair_term_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_seen |-> !hit);

endmodule

// File: rtl/pterm_map.sv
`timescale 1ns/1ps
module pterm_map #(
  parameter int unsigned TERMS  = 90,
  parameter int unsigned WORD_W = 44,
  localparam int unsigned ADDR_W = $clog2(TERMS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [TERMS*WORD_W-1:0]  map_flat
);

  logic [TERMS-1:0][WORD_W-1:0] map_q;
  logic                         addr_ok;

  assign addr_ok  = 32'(wr_addr) < TERMS;
  assign map_flat = map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '1;
    end else if (wr_en && addr_ok) begin
      map_q[wr_addr] <= wr_data;
    end
  end

  assert_word_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_ok) |=> map_q[$past(wr_addr)] == $past(wr_data));

  assert_idle_map_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !addr_ok) |=> $stable(map_q));

endmodule

// File: rtl/pterm_group.sv
`timescale 1ns/1ps
module pterm_group
  import pterm_pkg::*;
#(
  parameter int unsigned VEC_W     = 22,
  parameter int unsigned SUM_TERMS = 8,
  localparam int unsigned WORD_W   = LIT_BITS * VEC_W,
  localparam int unsigned SLOTS    = SUM_TERMS + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS*WORD_W-1:0] words,
  input  logic [VEC_W-1:0]        vec,
  output logic                    sum,
  output logic                    en_term
);

  logic [SLOTS-1:0] hits;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    pterm_eval #(.VEC_W(VEC_W)) i_term (
      .clk  (clk),
      .rst_n(rst_n),
      .word (words[s*WORD_W +: WORD_W]),
      .vec  (vec),
      .hit  (hits[s])
    );
  end

  assign sum     = |hits[SUM_TERMS-1:0];
  assign en_term = hits[SUM_TERMS];

endmodule

// File: rtl/prog_pterm_array.sv
`timescale 1ns/1ps
module prog_pterm_array
  import pterm_pkg::*;
#(
  parameter int unsigned DED_W     = 12,
  parameter int unsigned OUT_W     = 10,
  parameter int unsigned SUM_TERMS = 8,
  localparam int unsigned VEC_W    = DED_W + OUT_W,
  localparam int unsigned WORD_W   = LIT_BITS * VEC_W,
  localparam int unsigned SLOTS    = SUM_TERMS + 1,
  localparam int unsigned TERMS    = OUT_W * SLOTS,
  localparam int unsigned ADDR_W   = $clog2(TERMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic [DED_W-1:0]  ded_in,
  input  logic [OUT_W-1:0]  fb_in,
  output logic [OUT_W-1:0]  sum_out,
  output logic [OUT_W-1:0]  oe_term
);

  logic                    take;
  logic [TERMS*WORD_W-1:0] map_flat;
  logic [VEC_W-1:0]        vec;

  // Array vector: dedicated inputs in the low bits, feedback above them.
  assign vec = {fb_in, ded_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ready <= 1'b0;
    else        cfg_ready <= 1'b1;
  end

  assign take = cfg_valid && cfg_ready;

  pterm_map #(.TERMS(TERMS), .WORD_W(WORD_W)) i_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .map_flat(map_flat)
  );

  for (genvar o = 0; o < OUT_W; o++) begin : g_out
    localparam int unsigned BASE = term_addr(o, 0, SLOTS);
    pterm_group #(.VEC_W(VEC_W), .SUM_TERMS(SUM_TERMS)) i_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .words  (map_flat[BASE*WORD_W +: SLOTS*WORD_W]),
      .vec    (vec),
      .sum    (sum_out[o]),
      .en_term(oe_term[o])
    );
  end

  // Checks: the outputs stay quiet until the first write after reset; ready never drops outside reset.
  logic wrote_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wrote_q <= 1'b0;
    else if (take) wrote_q <= 1'b1;
  end

  assert_blank_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote_q |-> (sum_out == '0 && oe_term == '0));

  assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);

endmodule

// File: tb/test_prog_pterm_array.sv
`timescale 1ns/1ps
module test_prog_pterm_array;

  localparam int DED_W = 12;
  localparam int OUT_W = 10;
  localparam int SLOTS = 9;
  localparam int VEC_W = DED_W + OUT_W;
  localparam int WORD_W = 2 * VEC_W;
  localparam int TERMS = OUT_W * SLOTS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic              cfg_ready;
  logic [6:0]        cfg_addr = '0;
  logic [WORD_W-1:0] cfg_data = '0;
  logic [DED_W-1:0]  ded_in = '0;
  logic [OUT_W-1:0]  fb_in = '0;
  logic [OUT_W-1:0]  sum_out;
  logic [OUT_W-1:0]  oe_term;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit model_on = 0;
  logic [WORD_W-1:0] mmap [TERMS];

  always #5 clk = ~clk;

  prog_pterm_array i_prog_pterm_array (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ded_in(ded_in), .fb_in(fb_in),
    .sum_out(sum_out), .oe_term(oe_term)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_term(input int k);
    logic [VEC_W-1:0] v;
    bit r;
    v = {fb_in, ded_in};
    r = 1;
    for (int i = 0; i < VEC_W; i++) begin
      if (mmap[k][2*i] && !v[i]) r = 0;
      if (mmap[k][2*i+1] && v[i]) r = 0;
    end
    return r;
  endfunction

  // Reference compare on every cycle: R5 sums, R6 enable terms.
  always @(negedge clk) begin
    if (model_on && !done) begin
      logic [OUT_W-1:0] es, eo;
      es = '0; eo = '0;
      for (int o = 0; o < OUT_W; o++) begin
        for (int s = 0; s < SLOTS - 1; s++) es[o] = es[o] | model_term(o*SLOTS + s);
        eo[o] = model_term(o*SLOTS + SLOTS - 1);
      end
      check("R5 sum_out vs model", 32'(sum_out), 32'(es));
      check("R6 oe_term vs model", 32'(oe_term), 32'(eo));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Called just after a posedge; returns just after the edge that takes the word.
  task automatic wr(input int addr, input logic [WORD_W-1:0] d, input bit v);
    cfg_valid = v; cfg_addr = 7'(addr); cfg_data = d;
    @(posedge clk); #1;
    if (v && cfg_ready && addr < TERMS) mmap[addr] = d;
    cfg_valid = 1'b0;
  endtask

  task automatic blank_model();
    for (int k = 0; k < TERMS; k++) mmap[k] = '1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    logic [OUT_W-1:0] s_before, o_before;
    logic [WORD_W-1:0] w;
    blank_model();
    ded_in = 12'hA5C; fb_in = 10'h2F1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 ready low in reset", 32'(cfg_ready), 0);
    check("R7 sums low in reset", 32'(sum_out), 0);
    check("R7 enables low in reset", 32'(oe_term), 0);
    step();
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);
    check("R9 ready low before first edge", 32'(cfg_ready), 0);
    step();
    @(negedge clk);
    check("R9 ready high after release", 32'(cfg_ready), 1);
    fb_in = 10'h3FF; ded_in = 12'hFFF;
    @(negedge clk);
    check("R7 blank map sums", 32'(sum_out), 0);
    check("R7 blank map enables", 32'(oe_term), 0);
    step();

    // R3: open term on output 0 slot 0
    wr(0, '0, 1);
    @(negedge clk);
    check("R3 open term drives sum_out[0]", 32'(sum_out[0]), 1);
    ded_in = '0; fb_in = '0;
    @(negedge clk);
    check("R3 open term any input", 32'(sum_out[0]), 1);
    step();

    // R2/R1: output 1 slot 2 = ded_in[0] & ~fb_in[3] (word bits 0 and 31)
    w = '0; w[0] = 1'b1; w[2*(DED_W+3)+1] = 1'b1;
    wr(1*SLOTS + 2, w, 1);
    ded_in[0] = 1'b1; fb_in[3] = 1'b0;
    @(negedge clk);
    check("R2 true and inverted literal met", 32'(sum_out[1]), 1);
    step();
    fb_in[3] = 1'b1;
    @(negedge clk);
    check("R1 feedback bit 3 blocks term", 32'(sum_out[1]), 0);
    step();
    ded_in[0] = 1'b0; fb_in[3] = 1'b0;
    @(negedge clk);
    check("R2 dedicated bit 0 blocks term", 32'(sum_out[1]), 0);
    step();

    // R4: both literals of ded_in[2] on output 2 slot 0
    w = '0; w[4] = 1'b1; w[5] = 1'b1;
    wr(2*SLOTS, w, 1);
    ded_in[2] = 1'b0;
    @(negedge clk);
    check("R4 pair term low, input 0", 32'(sum_out[2]), 0);
    step();
    ded_in[2] = 1'b1;
    @(negedge clk);
    check("R4 pair term low, input 1", 32'(sum_out[2]), 0);
    step();

    // R6: open term in the enable slot of output 3
    wr(3*SLOTS + 8, '0, 1);
    @(negedge clk);
    check("R6 enable term high", 32'(oe_term[3]), 1);
    check("R6 enable term kept out of sum", 32'(sum_out[3]), 0);
    step();

    // R5: last sum slot of output 4 = ~ded_in[11] (word bit 23)
    w = '0; w[2*11+1] = 1'b1;
    wr(4*SLOTS + 7, w, 1);
    ded_in[11] = 1'b0;
    @(negedge clk);
    check("R5 last slot ORed into sum", 32'(sum_out[4]), 1);
    // R10: same cycle response, no edge
    ded_in[11] = 1'b1; #1;
    check("R10 combinational fall", 32'(sum_out[4]), 0);
    ded_in[11] = 1'b0; #1;
    check("R10 combinational rise", 32'(sum_out[4]), 1);
    step();

    // R9: out-of-range address changes nothing
    @(negedge clk);
    s_before = sum_out; o_before = oe_term;
    step();
    wr(100, '0, 1);
    @(negedge clk);
    check("R9 high address sums", 32'(sum_out), 32'(s_before));
    check("R9 high address enables", 32'(oe_term), 32'(o_before));
    step();

    // R8: valid low changes nothing
    wr(5*SLOTS, '0, 0);
    @(negedge clk);
    check("R8 valid low ignored", 32'(sum_out[5]), 0);
    step();

    // R8: takes effect at the accepting edge
    cfg_valid = 1'b1; cfg_addr = 7'(6*SLOTS); cfg_data = '0;
    @(negedge clk);
    check("R8 before accepting edge", 32'(sum_out[6]), 0);
    @(posedge clk); #1;
    mmap[6*SLOTS] = '0; cfg_valid = 1'b0;
    @(negedge clk);
    check("R8 after accepting edge", 32'(sum_out[6]), 1);
    step();

    // R8: back-to-back writes, then overwrite of slot 0 word
    wr(7*SLOTS + 1, '0, 1);
    wr(8*SLOTS + 3, '0, 1);
    wr(0, '1, 1);
    @(negedge clk);
    check("R8 back-to-back first", 32'(sum_out[7]), 1);
    check("R8 back-to-back second", 32'(sum_out[8]), 1);
    check("R8 overwrite replaces word", 32'(sum_out[0]), 0);
    step();

    // R5: random sparse maps, compared every cycle
    for (int n = 0; n < 600; n++) begin
      w = '0;
      for (int k = 0; k < 3; k++) begin
        int b;
        b = $urandom_range(0, VEC_W - 1);
        w[2*b + $urandom_range(0, 1)] = 1'b1;
      end
      if ($urandom_range(0, 7) == 0) begin
        int b;
        b = $urandom_range(0, VEC_W - 1);
        w[2*b] = 1'b1; w[2*b+1] = 1'b1;
      end
      ded_in = 12'($urandom); fb_in = 10'($urandom);
      wr(($urandom_range(0, 15) == 0) ? $urandom_range(TERMS, 127) : $urandom_range(0, TERMS - 1),
         w, $urandom_range(0, 3) != 0);
      for (int c = 0; c < 2; c++) begin
        ded_in = 12'($urandom); fb_in = 10'($urandom);
        step();
      end
    end

    // R7/R9: second reset blanks the map again
    rst_n = 1'b0;
    blank_model();
    @(negedge clk);
    check("R9 ready low on second reset", 32'(cfg_ready), 0);
    check("R7 sums blank after second reset", 32'(sum_out), 0);
    check("R7 enables blank after second reset", 32'(oe_term), 0);
    step();
    finish_run();
  end

endmodule